// File: doc/BRIEF.md
# CPU Condition Code Register Unit

This block holds the 8-bit flag byte of a small 8-bit processor. Each time an arithmetic or logic operation is issued, it takes the two operands and a carry input and works out carry, zero, negative, signed overflow and nibble carry. The flags that apply to the operation class are written into the register on the next clock edge. The same byte holds the interrupt mask. The mask blocks the maskable interrupt request on its way to the sequencer. Software can load the byte directly, for example when flags are restored on return from an interrupt.

Interrupt entry is tracked by a two-state sequencer. In state OPEN, the mask follows direct writes. The transition OPEN to MASKED is taken on the strobe that signals that the CPU registers have been pushed, and that same edge sets the mask. In state MASKED, the mask is held at 1 whatever a direct write carries. The transition MASKED to OPEN is taken on the vector-fetch strobe. The mask is therefore always set before the vector is read.

Top module: `ccr_unit`

## Requirements
- R1: After reset the byte reads 0x68: mask (bit 3) is 1, bits 6 and 5 are 1, and the flags V (bit 7), H (bit 4), N (bit 2), Z (bit 1) and C (bit 0) are 0.
- R2: Bits 6 and 5 read 1 at all times. Writing 0 to them has no effect.
- R3: With `op_class` 0 (add) the result is A+B and `carry_in` is ignored. With `op_class` 1 (add with carry) the result is A+B+`carry_in`. For both, C is the carry out of bit 7, V is two's complement overflow, H is the carry from bit 3 into bit 4, N is result bit 7, and Z is set for a zero result.
- R4: With `op_class` 2 (subtract) the result is A-B. C is the borrow, V is signed overflow, N and Z follow the result, and H keeps its value.
- R5: With `op_class` 3 (logic or transfer) the result is operand A. N and Z follow it, V is cleared, and H and C keep their values.
- R6: Flags change on the clock edge where `alu_en` is high. With `alu_en`, `wr_en` and `stk_done` all low, the byte holds.
- R7: A direct write loads bits 7, 4, 3, 2, 1 and 0 from `wr_data` on the next edge. A direct write takes priority over a flag update in the same cycle.
- R8: `irq_gated` equals `irq_req` while the mask is 0 and is 0 while the mask is 1, with no clock delay.
- R9: `stk_done` sets the mask on the next edge, even when a direct write in the same cycle carries 0 for it.
- R10: From the `stk_done` edge until the `vec_fetch` edge, direct writes leave the mask at 1. After `vec_fetch`, writes control the mask again.
- R11: `vec_fetch` outside the masked window leaves the byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_en | input | 1 | Operation issued this cycle; update the flags |
| op_class | input | 2 | 0 add, 1 add with carry, 2 subtract, 3 logic/transfer |
| opnd_a | input | 8 | First operand (the result itself for logic class) |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry input, used by add with carry |
| wr_en | input | 1 | Direct load of the byte |
| wr_data | input | 8 | Byte to load |
| stk_done | input | 1 | CPU registers have been pushed during interrupt entry |
| vec_fetch | input | 1 | Interrupt vector is being fetched |
| irq_req | input | 1 | Maskable interrupt request |
| ccr | output | 8 | Flag byte: V,1,1,H,I,N,Z,C from bit 7 to bit 0 |
| irq_gated | output | 1 | Request after the mask |

## Verification
A wrong flag state appears on `ccr` one cycle after the operation that produced it. A flag that should have been kept, such as H after a subtract, appears only as a changed bit in that same sample. A sequencer stuck in MASKED shows only when a later direct write fails to clear the mask, so the bench writes the mask both inside and after the window. A mask that is wrong at any moment shows on `irq_gated` in the same cycle, because that output has no register.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int DATA_W = 8;
    localparam int CCR_W  = 8;

    localparam int BIT_V = 7;
    localparam int BIT_H = 4;
    localparam int BIT_I = 3;
    localparam int BIT_N = 2;
    localparam int BIT_Z = 1;
    localparam int BIT_C = 0;

    localparam logic [CCR_W-1:0] FIX_MASK = 8'h60;
    localparam logic [CCR_W-1:0] CCR_RST  = 8'h68;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_ADC   = 2'd1,
        OP_SUB   = 2'd2,
        OP_LOGIC = 2'd3
    } op_class_e;

    typedef enum logic {
        ENT_OPEN   = 1'b0,
        ENT_MASKED = 1'b1
    } ent_state_e;

    typedef struct packed {
        logic v;
        logic h;
        logic n;
        logic z;
        logic c;
        logic upd_h;
        logic upd_c;
    } flag_res_t;
endpackage

// File: rtl/ccr_flag_gen.sv
module ccr_flag_gen
    import ccr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  op_class_e       op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            cin,
    output flag_res_t       res
);
    localparam int HB = DW / 2;

    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic [DW:0]   sum;
    logic [DW-1:0] r;

    // operand conditioning per class
    always_comb begin
        unique case (op)
            OP_ADD:   begin b_eff = b;  c_eff = 1'b0; end
            OP_ADC:   begin b_eff = b;  c_eff = cin;  end
            OP_SUB:   begin b_eff = ~b; c_eff = 1'b1; end
            OP_LOGIC: begin b_eff = b;  c_eff = 1'b0; end
        endcase
    end

    assign sum = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
    assign r   = (op == OP_LOGIC) ? a : sum[DW-1:0];

    always_comb begin
        res.n     = r[DW-1];
        res.z     = (r == '0);
        // carry into bit HB recovered from sum and operand bits
        res.h     = sum[HB] ^ a[HB] ^ b_eff[HB];
        res.v     = (op != OP_LOGIC) && (a[DW-1] == b_eff[DW-1]) && (r[DW-1] != a[DW-1]);
        res.c     = (op == OP_SUB) ? ~sum[DW] : sum[DW];
        res.upd_h = (op == OP_ADD) || (op == OP_ADC);
        res.upd_c = (op != OP_LOGIC);
    end
endmodule

// File: rtl/ccr_entry_seq.sv
module ccr_entry_seq
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stk_done,
    input  logic vec_fetch,
    output logic set_i,
    output logic hold_i
);
    ent_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENT_OPEN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_OPEN:   if (stk_done)                state_d = ENT_MASKED;
            ENT_MASKED: if (vec_fetch && !stk_done)  state_d = ENT_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        set_i  = stk_done;
        hold_i = 1'b0;
        unique case (state_q)
            ENT_OPEN:   hold_i = 1'b0;
            ENT_MASKED: hold_i = 1'b1;
        endcase
    end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alu_en,
    input  logic [1:0]    op_class,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          carry_in,
    input  logic          wr_en,
    input  logic [CCR_W-1:0] wr_data,
    input  logic          stk_done,
    input  logic          vec_fetch,
    input  logic          irq_req,
    output logic [CCR_W-1:0] ccr,
    output logic          irq_gated
);
    op_class_e        op_e;
    flag_res_t        fres;
    logic             set_i;
    logic             hold_i;
    logic [CCR_W-1:0] ccr_q, ccr_d;

    assign op_e = op_class_e'(op_class);

    ccr_flag_gen #(.DW(DW)) u_flags (
        .op  (op_e),
        .a   (opnd_a),
        .b   (opnd_b),
        .cin (carry_in),
        .res (fres)
    );

    ccr_entry_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stk_done  (stk_done),
        .vec_fetch (vec_fetch),
        .set_i     (set_i),
        .hold_i    (hold_i)
    );

    // next byte: write beats flag update; entry forces the mask
    always_comb begin
        ccr_d = ccr_q;
        if (wr_en) begin
            ccr_d = wr_data;
        end else if (alu_en) begin
            ccr_d[BIT_V] = fres.v;
            ccr_d[BIT_N] = fres.n;
            ccr_d[BIT_Z] = fres.z;
            if (fres.upd_h) ccr_d[BIT_H] = fres.h;
            if (fres.upd_c) ccr_d[BIT_C] = fres.c;
        end
        if (set_i || hold_i) ccr_d[BIT_I] = 1'b1;
        ccr_d = ccr_d | FIX_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ccr_q <= CCR_RST;
        else        ccr_q <= ccr_d;
    end

    assign ccr       = ccr_q;
    assign irq_gated = irq_req && !ccr_q[BIT_I];
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alu_en,
    input logic [1:0] op_class,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       stk_done,
    input logic       irq_req,
    input logic [7:0] ccr,
    input logic       irq_gated,
    input logic       hold_i
);
    // R2
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ccr[6:5] == 2'b11);

    // R8
    irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ccr[3] |-> !irq_gated);

    // R8
    irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ccr[3]) |-> irq_gated);

    // R9
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_done |=> ccr[3]);

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> ccr[3]);

    // R5
    logic_v_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_en && !wr_en && op_class == 2'd3) |=> !ccr[7]);

    // R4
    h_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_en && !wr_en && op_class[1]) |=> $stable(ccr[4]));

    // R7
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stk_done && !hold_i) |=> ccr == ($past(wr_data) | 8'h60));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_en && !wr_en && !stk_done) |=> $stable(ccr));
endmodule

bind ccr_unit ccr_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_en    (alu_en),
    .op_class  (op_class),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .stk_done  (stk_done),
    .irq_req   (irq_req),
    .ccr       (ccr),
    .irq_gated (irq_gated),
    .hold_i    (hold_i)
);

// File: tb/ccr_unit_tb.sv
`timescale 1ns/100ps
module ccr_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alu_en = 1'b0;
    logic [1:0] op_class = 2'd0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic       carry_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stk_done = 1'b0;
    logic       vec_fetch = 1'b0;
    logic       irq_req = 1'b0;
    logic [7:0] ccr;
    logic       irq_gated;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ccr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .op_class(op_class),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .wr_en(wr_en), .wr_data(wr_data), .stk_done(stk_done),
        .vec_fetch(vec_fetch), .irq_req(irq_req),
        .ccr(ccr), .irq_gated(irq_gated)
    );

    // {op, a, b, cin, expected byte}; applied in order, state carries over
    localparam logic [26:0] VEC [10] = '{
        {2'd0, 8'h0F, 8'h01, 1'b0, 8'h78},  // R3 nibble carry
        {2'd0, 8'h7F, 8'h01, 1'b0, 8'hFC},  // R3 overflow to negative
        {2'd0, 8'h80, 8'h80, 1'b0, 8'hEB},  // R3 carry, zero, overflow
        {2'd1, 8'hFF, 8'h00, 1'b1, 8'h7B},  // R3 carry-in ripples
        {2'd3, 8'h81, 8'h00, 1'b0, 8'h7D},  // R5 H and C kept, V cleared
        {2'd2, 8'h80, 8'h01, 1'b0, 8'hF8},  // R4 signed overflow, no borrow
        {2'd1, 8'h05, 8'h03, 1'b0, 8'h68},  // R3 all clear
        {2'd0, 8'h01, 8'h01, 1'b1, 8'h68},  // R3 carry_in ignored for add
        {2'd2, 8'h05, 8'h05, 1'b0, 8'h6A},  // R4 zero result
        {2'd1, 8'h08, 8'h08, 1'b1, 8'h78}   // R3 nibble carry with cin
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        irq_req = 1'b1;
        #13 rst_n = 1'b1;
        #1;
        // R1 reset byte and blocked request
        check("R1 reset byte", ccr, 8'h68);
        check("R1 irq blocked after reset", {7'd0, irq_gated}, 8'h00);

        for (int k = 0; k < 10; k++) begin
            alu_en   = 1'b1;
            op_class = VEC[k][26:25];
            opnd_a   = VEC[k][24:17];
            opnd_b   = VEC[k][16:9];
            carry_in = VEC[k][8];
            tick();
            alu_en = 1'b0;
            check($sformatf("R3/R4/R5 vector %0d", k), ccr, VEC[k][7:0]);
        end

        // R6 no update without alu_en
        op_class = 2'd0; opnd_a = 8'hFF; opnd_b = 8'hFF;
        tick();
        check("R6 hold without alu_en", ccr, 8'h78);

        // R7 and R2: write beats flag update, fixed bits stay set
        alu_en = 1'b1; op_class = 2'd0; opnd_a = 8'h7F; opnd_b = 8'h01;
        wr(8'hD7);
        alu_en = 1'b0;
        check("R7 write over update, R2 fixed bits", ccr, 8'hF7);
        check("R8 request passes with mask clear", {7'd0, irq_gated}, 8'h01);

        wr(8'h00);
        check("R7 write zero, R2 fixed bits", ccr, 8'h60);

        // R9 stacking with a concurrent write of 0
        stk_done = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        tick();
        stk_done = 1'b0; wr_en = 1'b0;
        check("R9 mask set on stacking", ccr, 8'h68);
        check("R8 request blocked in window", {7'd0, irq_gated}, 8'h00);

        // R10 mask held in window
        wr(8'h00);
        check("R10 write cannot clear mask in window", ccr, 8'h68);

        vec_fetch = 1'b1;
        tick();
        vec_fetch = 1'b0;
        check("R10 mask set at vector fetch", ccr, 8'h68);

        wr(8'h00);
        check("R10 write clears mask after window", ccr, 8'h60);

        // R11 vector fetch outside the window
        vec_fetch = 1'b1;
        tick();
        vec_fetch = 1'b0;
        check("R11 stray vector fetch", ccr, 8'h60);
        check("R8 request passes again", {7'd0, irq_gated}, 8'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule